// File: doc/BRIEF.md
# Pixel Subarray Bitplane Serializer

An 8 by 8 group of pixel sigma-delta modulators gives one new bit per pixel on every modulator clock. Each such clock therefore produces a fresh 64-bit plane. This block takes each plane in through eight row lanes and sends it to a downstream processor as a single serial stream. It runs on the fast serial clock. The modulator clock reaches it as a one-cycle strobe, `plane_tick`, that is synchronous to the serial clock. The serial clock must be at least 64 times faster than the strobe, so that a whole plane is sent before the next one arrives.

A strobe takes a snapshot of all pixel bits into a shadow store. Over the next 64 cycles the block sends them out. It raises `ser_valid` on every bit and `ser_start` on the first bit of each plane.

A control machine with two states sets the pace:
- **ST_IDLE**: the block sends nothing.
- **ST_SHIFT**: the block sends one bit per cycle.

It has four named transitions:
- **T_START**: ST_IDLE to ST_SHIFT when a strobe arrives.
- **T_STEP**: stays in ST_SHIFT and moves to the next bit.
- **T_CHAIN**: stays in ST_SHIFT and reloads when a strobe meets the last bit.
- **T_DONE**: ST_SHIFT to ST_IDLE after the last bit when no strobe arrives.

If a strobe comes while a plane is still part-way out, that new plane is dropped and a sticky overrun flag is set.

Top module: `bitplane_serializer`

## Requirements
- R1: Synchronous reset clears the shadow store, the bit counter and the overrun flag. In the cycle after reset is released, `ser_valid`, `ser_start`, `ser_data` and `overrun` are all 0.
- R2: A `plane_tick` seen in ST_IDLE captures `pix_bits` at that edge. The next cycle shows the first bit with `ser_valid`=1. The 64 bits then follow on 64 consecutive cycles.
- R3: The pixel at row r, column c is input bit `pix_bits[r*8+c]`. It is sent as serial bit number r*8+c, counted from 0. Row 0 goes first and row 7 last, and within each row column 0 goes first and column 7 last.
- R4: `ser_start` is 1 exactly on serial bit 0 of each plane and 0 on every other cycle.
- R5: A `plane_tick` in the cycle that shows bit 63 captures the new plane. Its bit 0 follows in the very next cycle with no gap, and `overrun` is not set.
- R6: A `plane_tick` in a cycle that shows bits 0 to 62 is ignored and sets `overrun`. The plane being sent continues unchanged.
- R7: Once set, `overrun` stays 1 until reset.
- R8: After bit 63, with no strobe, the block returns to ST_IDLE. While idle, `ser_valid`, `ser_start` and `ser_data` are 0.
- R9: Changes on `pix_bits` between strobes do not affect the plane being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| plane_tick | input | 1 | One-cycle strobe marking a modulator clock |
| pix_bits | input | 64 | Pixel bits, row r column c at bit r*8+c |
| ser_data | output | 1 | Serial bit |
| ser_valid | output | 1 | High while `ser_data` carries a bit |
| ser_start | output | 1 | High on bit 0 of each plane |
| overrun | output | 1 | Sticky flag: a plane arrived mid-transfer |

## Verification
A wrong bit count or a wrong state shows up within one plane. Depending on the fault, `ser_valid` stops early or runs long, `ser_start` moves away from the 64-cycle boundary, or a back-to-back plane arrives with a gap. A wrong shadow store, or one that reloads when it should not, corrupts `ser_data` on the first affected bit. This is why each bit is compared against the captured plane while the pixel inputs are scrambled. A mishandled overrun shows on the flag in the cycle after the offending strobe. It also shows in the rest of the plane, because the bits switch to the dropped plane.

// File: rtl/bpser_pkg.sv
package bpser_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/bpser_lane.sv
module bpser_lane #(
    parameter int COLS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [COLS-1:0] row_in,
    output logic [COLS-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (load)
            row_q <= row_in;
    end
endmodule

// File: rtl/bpser_ctrl.sv
module bpser_ctrl
    import bpser_pkg::*;
#(
    parameter int BITS = 64,
    localparam int CW = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic          load,
    output logic          busy,
    output logic [CW-1:0] idx,
    output logic          ovr
);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    ctl_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ovr_q, ovr_set;

    // Next-state and load decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        ovr_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) begin            // T_START
                    load    = 1'b1;
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                end
            end
            ST_SHIFT: begin
                if (cnt_q == LAST) begin
                    if (tick) begin        // T_CHAIN
                        load  = 1'b1;
                        cnt_d = '0;
                    end else begin         // T_DONE
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end else begin             // T_STEP
                    cnt_d   = cnt_q + 1'b1;
                    ovr_set = tick;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovr_q   <= ovr_q | ovr_set;
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_SHIFT);
        idx  = cnt_q;
        ovr  = ovr_q;
    end
endmodule

// File: rtl/bpser_pick.sv
module bpser_pick #(
    parameter int BITS = 64,
    localparam int CW = $clog2(BITS)
) (
    input  logic [BITS-1:0] plane,
    input  logic [CW-1:0]   sel,
    input  logic            en,
    output logic            bit_o
);
    always_comb bit_o = en & plane[sel];
endmodule

// File: rtl/bitplane_serializer.sv
module bitplane_serializer #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 plane_tick,
    input  logic [ROWS*COLS-1:0] pix_bits,
    output logic                 ser_data,
    output logic                 ser_valid,
    output logic                 ser_start,
    output logic                 overrun
);
    localparam int BITS = ROWS * COLS;
    localparam int CW   = $clog2(BITS);

    logic            load, busy;
    logic [CW-1:0]   idx;
    logic [BITS-1:0] shadow;

    bpser_ctrl #(.BITS(BITS)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .tick (plane_tick),
        .load (load),
        .busy (busy),
        .idx  (idx),
        .ovr  (overrun)
    );

    // One sense lane per pixel row
    for (genvar r = 0; r < ROWS; r++) begin : g_lane
        bpser_lane #(.COLS(COLS)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .row_in (pix_bits[r*COLS +: COLS]),
            .row_q  (shadow[r*COLS +: COLS])
        );
    end

    bpser_pick #(.BITS(BITS)) u_pick (
        .plane (shadow),
        .sel   (idx),
        .en    (busy),
        .bit_o (ser_data)
    );

    assign ser_valid = busy;
    assign ser_start = busy && (idx == '0);
endmodule

// File: rtl/bpser_checker.sv
module bpser_checker #(
    parameter int BITS = 64
) (
    input logic clk,
    input logic rst,
    input logic plane_tick,
    input logic ser_data,
    input logic ser_valid,
    input logic ser_start,
    input logic overrun
);
    localparam int RW = $clog2(BITS) + 1;
    logic [RW-1:0] run;

    // Number of bits of the current plane already sent
    always_ff @(posedge clk) begin
        if (rst)            run <= '0;
        else if (ser_start) run <= RW'(1);
        else if (ser_valid) run <= run + 1'b1;
        else                run <= '0;
    end

    AST_START_IN_VALID: assert property (@(posedge clk) disable iff (rst)
        ser_start |-> ser_valid);                                          // R4
    AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        ser_start |-> (run == '0 || run == RW'(BITS)));                    // R5
    AST_PLANE_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && !ser_start) |-> (run != '0 && run < RW'(BITS)));     // R2
    AST_START_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        ser_start |-> $past(plane_tick));                                  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ser_valid |-> (!ser_data && !ser_start));                         // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);                                              // R7
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(plane_tick) && $past(ser_valid)));       // R6
endmodule

bind bitplane_serializer bpser_checker #(.BITS(ROWS*COLS)) u_bpser_checker (
    .clk        (clk),
    .rst        (rst),
    .plane_tick (plane_tick),
    .ser_data   (ser_data),
    .ser_valid  (ser_valid),
    .ser_start  (ser_start),
    .overrun    (overrun)
);

// File: tb/test_bitplane_serializer.sv
module test_bitplane_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        plane_tick = 1'b0;
    logic [63:0] pix_bits = '0;
    logic        ser_data, ser_valid, ser_start, overrun;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    bitplane_serializer i_bitplane_serializer (
        .clk(clk), .rst(rst), .plane_tick(plane_tick), .pix_bits(pix_bits),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_start(ser_start),
        .overrun(overrun)
    );

    function automatic int plane_idx(input int r, input int c);
        return r * 8 + c;
    endfunction

    function automatic logic exp_bit(input logic [63:0] p, input int k);
        return p[k];
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [63:0] p);
        pix_bits   = p;
        plane_tick = 1'b1;
        @(negedge clk);
        plane_tick = 1'b0;
    endtask

    // Entered with bit 0 of p on the outputs
    task automatic run_plane(input logic [63:0] p, input int tick_at, input logic [63:0] nxt,
                             input logic exp_ovr_after);
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                int k;
                k = plane_idx(r, c);
                chk(ser_valid, 1, "R2 valid");
                chk(ser_data, exp_bit(p, k), "R3 data order");
                chk(ser_start, (k == 0), "R4 start marker");
                if (k == tick_at) begin
                    pix_bits   = nxt;
                    plane_tick = 1'b1;
                end else begin
                    pix_bits = rnd64();        // R9 scramble inputs
                end
                @(negedge clk);
                plane_tick = 1'b0;
                if (tick_at >= 0 && tick_at < 63 && k == tick_at)
                    chk(overrun, 1, "R6 overrun set");
            end
        end
        chk(overrun, exp_ovr_after, "R7 overrun level");
    endtask

    task automatic chk_idle();
        chk(ser_valid, 0, "R8 idle valid");
        chk(ser_start, 0, "R8 idle start");
        chk(ser_data, 0, "R8 idle data");
    endtask

    initial begin
        logic [63:0] a, b, c;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_valid, 0, "R1 valid");
        chk(ser_start, 0, "R1 start");
        chk(ser_data, 0, "R1 data");
        chk(overrun, 0, "R1 overrun");

        // Directed pattern, plane goes idle after
        launch(64'hA5C3_0F1E_8001_7FFE);
        run_plane(64'hA5C3_0F1E_8001_7FFE, -1, '0, 0);
        chk_idle();

        // Corner planes: all ones then all zeros, chained (R5)
        launch('1);
        run_plane('1, 63, '0, 0);
        run_plane('0, -1, '0, 0);
        chk_idle();

        // Random chained planes (R5)
        a = rnd64();
        launch(a);
        for (int i = 0; i < 6; i++) begin
            b = rnd64();
            run_plane(a, 63, b, 0);
            a = b;
        end
        run_plane(a, -1, '0, 0);
        chk_idle();

        // Strobe mid-plane: new plane dropped (R6)
        a = rnd64();
        c = ~a;
        launch(a);
        run_plane(a, 10, c, 1);
        chk_idle();

        // Strobe on bit 0 also an overrun case; flag stays (R7)
        a = rnd64();
        launch(a);
        run_plane(a, 0, rnd64(), 1);
        chk_idle();
        repeat (5) @(negedge clk);
        chk(overrun, 1, "R7 sticky while idle");

        // Reset clears the flag (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(overrun, 0, "R1 overrun after reset");
        chk(ser_valid, 0, "R1 valid after reset");

        // Random planes with idle gaps
        for (int i = 0; i < 20; i++) begin
            a = rnd64();
            launch(a);
            run_plane(a, -1, '0, 0);
            chk_idle();
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule